// File: doc/BRIEF.md
# Stacked-DRAM Cache Tag Controller

This block manages a large last-level cache. The tags sit in a small on-chip array, and the data sits in stacked DRAM. Each request from the L2 side carries an address and a read/write flag. The controller looks the address up in the tag array, which is 8-way set associative, and it does this before it touches the DRAM. The set and way of the matching tag map straight onto a DRAM data slot. The controller then moves only the 128-byte L2-sized piece of the 1024-byte line that the request names.

On a miss the controller picks a victim way. If the victim holds modified data, it first copies the whole victim line out of DRAM and into main memory. It then fetches the whole new line from main memory into the DRAM slot and serves the original request from the freshly filled line. Data moves directly between the devices. The controller only issues commands: each one is held until the addressed device pulses its done input.

Only one request is handled at a time. The request port stays closed from the moment a request is accepted until its response pulse.

Top module: `dram_cache_tagctl`

## Requirements
- R1: Request address bits [9:7] pick the 128-byte chunk. Bits [13:10] pick one of 16 sets. Bits [31:14] are the tag. Bits [6:0] are ignored.
- R2: On a hit the block issues exactly one DRAM chunk command, with `dram_full`=0 and `dram_write` equal to the request's write flag, at address (set×8+way)×1024 + chunk×128. It issues no main-memory command, and it answers with `resp_hit`=1.
- R3: A write that hits marks that way modified, so its later eviction causes a write-back.
- R4: A miss whose victim is invalid or unmodified issues these commands in order:
  - a main-memory read (`mem_write`=0) of the 1024-aligned line;
  - a full-line DRAM write (`dram_full`=1) to (set×8+way)×1024;
  - the chunk command.
  It then answers with `resp_hit`=0.
- R5: A miss whose victim is valid and modified first issues a full-line DRAM read of the victim slot. It then issues a main-memory write (`mem_write`=1) to the victim's line address (old tag, same set, offset 0). Only after that does it fetch the new line.
- R6: The victim is the lowest-numbered invalid way. When all ways are valid, the victim comes from a 7-node binary-tree pseudo-LRU per set:
  - each node bit points toward the half that was used less recently (1 = upper half);
  - every hit or fill flips the nodes on its path to point away from the way it used.
- R7: `req_ready` is low from the acceptance of a request until its response, so requests that arrive meanwhile are held off.
- R8: `resp_valid` is a one-cycle pulse. A device command holds its address and kind until that device's done input is seen.
- R9: After reset no line is valid, `req_ready` is 1, and `resp_valid`, `dram_valid` and `mem_valid` are 0.
- R10: A write that misses allocates the line as modified and issues its chunk command with `dram_write`=1.
- R11: A line that has been evicted no longer hits; no two valid ways of a set hold the same tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | L2-side request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = L2 write-back of a chunk, 0 = read |
| req_addr | input | 32 | Byte address of the request |
| resp_valid | output | 1 | Request completed (one-cycle pulse) |
| resp_hit | output | 1 | Completed request hit in the tag array |
| dram_valid | output | 1 | DRAM command pending |
| dram_write | output | 1 | DRAM command writes the data slot |
| dram_full | output | 1 | 1 = whole 1024-byte line, 0 = one 128-byte chunk |
| dram_addr | output | 17 | DRAM byte address (set, way, chunk) |
| dram_done | input | 1 | DRAM finished the pending command |
| mem_valid | output | 1 | Main-memory command pending |
| mem_write | output | 1 | 1 = victim write-back, 0 = line fetch |
| mem_addr | output | 32 | Line-aligned main-memory address |
| mem_done | input | 1 | Main memory finished the pending command |

## Verification
The bench runs three kinds of traffic through separate sets:
- Repeated reads and writes to one resident line. These show that a hit yields only a single chunk command at the right slot offset.
- Fills of an empty set. These show that invalid ways are used lowest first, before the pseudo-LRU tree is ever consulted.
- Misses into a full set. Some of these miss onto an unmodified victim, others onto one modified by a write hit or a write miss. They show the tree's choice and whether a write-back precedes the fetch.

A final re-read of an evicted tag must miss. A request with a high tag, the last set, the last chunk and junk low bits checks the address split.

// File: rtl/dct_pkg.sv
package dct_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_LOOK,
    S_WBRD,
    S_WBWR,
    S_FRD,
    S_FWR,
    S_CHUNK,
    S_RESP
  } dct_state_e;
endpackage

// File: rtl/dct_tag_store.sv
module dct_tag_store #(
  parameter int SETS  = 16,
  parameter int WAYS  = 8,
  parameter int TAG_W = 18,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             hit,
  output logic [WAY_W-1:0] hit_way,
  output logic [WAYS-1:0]  vld_vec,
  output logic [WAYS-1:0]  dty_vec,
  input  logic [WAY_W-1:0] sel_way,
  output logic [TAG_W-1:0] sel_tag,
  input  logic             fill_en,
  input  logic [WAY_W-1:0] fill_way,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             fill_dirty,
  input  logic             mark_en,
  input  logic [WAY_W-1:0] mark_way
);

  logic [WAYS-1:0]  vld_q [SETS];
  logic [WAYS-1:0]  dty_q [SETS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [WAYS-1:0]  hit_vec;

  assign vld_vec = vld_q[lk_set];
  assign dty_vec = dty_q[lk_set];
  assign sel_tag = tag_q[lk_set][sel_way];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
  end

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end
  assign hit = |hit_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        dty_q[s] <= '0;
      end
    end else if (fill_en) begin
      vld_q[lk_set][fill_way] <= 1'b1;
      dty_q[lk_set][fill_way] <= fill_dirty;
    end else if (mark_en) begin
      dty_q[lk_set][mark_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[lk_set][fill_way] <= fill_tag;
  end

  // R11
  single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

endmodule

// File: rtl/dct_plru.sv
module dct_plru #(
  parameter int SETS = 16,
  parameter int WAYS = 8,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] set_idx,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] victim
);

  // node bits use heap numbering 1..WAYS-1; bit 0 is spare
  logic [WAYS-1:0] plru_q [SETS];
  logic [WAYS-1:0] cur_bits;
  logic [WAYS-1:0] nxt_bits;

  assign cur_bits = plru_q[set_idx];

  always_comb begin
    logic [WAY_W-1:0] node;
    logic             b;
    node   = WAY_W'(1);
    victim = '0;
    for (int l = 0; l < WAY_W; l++) begin
      b      = cur_bits[node];
      victim = {victim[WAY_W-2:0], b};
      node   = {node[WAY_W-2:0], b};
    end
  end

  always_comb begin
    logic [WAY_W-1:0] node;
    logic [WAY_W-1:0] tw;
    logic             dir;
    nxt_bits = cur_bits;
    node     = WAY_W'(1);
    tw       = touch_way;
    for (int l = 0; l < WAY_W; l++) begin
      dir            = tw[WAY_W-1];
      nxt_bits[node] = ~dir;
      node           = {node[WAY_W-2:0], dir};
      tw             = {tw[WAY_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) plru_q[s] <= '0;
    end else if (touch_en) begin
      plru_q[set_idx] <= nxt_bits;
    end
  end

  // R6
  recent_not_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> (victim != $past(touch_way)) || (set_idx != $past(set_idx)));

endmodule

// File: rtl/dram_cache_tagctl.sv
module dram_cache_tagctl #(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 16,
  parameter int WAYS       = 8,
  parameter int LINE_BYTES = 1024,
  parameter int L2_BYTES   = 128,
  localparam int SET_W   = $clog2(SETS),
  localparam int WAY_W   = $clog2(WAYS),
  localparam int OFF_W   = $clog2(LINE_BYTES),
  localparam int CHK_LSB = $clog2(L2_BYTES),
  localparam int CHK_W   = OFF_W - CHK_LSB,
  localparam int TAG_W   = ADDR_W - OFF_W - SET_W,
  localparam int DADDR_W = SET_W + WAY_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               resp_valid,
  output logic               resp_hit,
  output logic               dram_valid,
  output logic               dram_write,
  output logic               dram_full,
  output logic [DADDR_W-1:0] dram_addr,
  input  logic               dram_done,
  output logic               mem_valid,
  output logic               mem_write,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic               mem_done
);
  import dct_pkg::*;

  // reset: asserted at once, released through two flops
  logic rst_m, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  dct_state_e st_q, st_d;

  logic [TAG_W-1:0] tag_q, vtag_q;
  logic [SET_W-1:0] set_q;
  logic [CHK_W-1:0] chk_q;
  logic [WAY_W-1:0] way_q;
  logic             wr_q, hit_q;

  logic             unused_lo;
  assign unused_lo = ^req_addr[CHK_LSB-1:0];

  logic             lk_hit;
  logic [WAY_W-1:0] lk_way, plru_way, vic_way;
  logic [WAYS-1:0]  vld_vec, dty_vec;
  logic [TAG_W-1:0] vic_tag;
  logic             vic_dirty;
  logic             acc_en, look_en, fill_en, mark_en, touch_en;

  assign acc_en  = (st_q == S_IDLE) && req_valid;
  assign look_en = (st_q == S_LOOK);
  assign fill_en = (st_q == S_FWR) && dram_done;
  assign mark_en = look_en && lk_hit && wr_q;
  assign touch_en = (look_en && lk_hit) || fill_en;

  dct_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk        (clk),
    .rst_n      (rst_s),
    .lk_set     (set_q),
    .lk_tag     (tag_q),
    .hit        (lk_hit),
    .hit_way    (lk_way),
    .vld_vec    (vld_vec),
    .dty_vec    (dty_vec),
    .sel_way    (vic_way),
    .sel_tag    (vic_tag),
    .fill_en    (fill_en),
    .fill_way   (way_q),
    .fill_tag   (tag_q),
    .fill_dirty (wr_q),
    .mark_en    (mark_en),
    .mark_way   (lk_way)
  );

  dct_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
    .clk       (clk),
    .rst_n     (rst_s),
    .set_idx   (set_q),
    .touch_en  (touch_en),
    .touch_way (look_en ? lk_way : way_q),
    .victim    (plru_way)
  );

  // lowest invalid way first, tree choice otherwise
  always_comb begin
    vic_way = plru_way;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld_vec[w]) vic_way = WAY_W'(w);
    end
  end
  assign vic_dirty = vld_vec[vic_way] && dty_vec[vic_way];

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE:  if (req_valid) st_d = S_LOOK;
      S_LOOK:  st_d = lk_hit ? S_CHUNK : (vic_dirty ? S_WBRD : S_FRD);
      S_WBRD:  if (dram_done) st_d = S_WBWR;
      S_WBWR:  if (mem_done) st_d = S_FRD;
      S_FRD:   if (mem_done) st_d = S_FWR;
      S_FWR:   if (dram_done) st_d = S_CHUNK;
      S_CHUNK: if (dram_done) st_d = S_RESP;
      S_RESP:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (acc_en) begin
      tag_q <= req_addr[ADDR_W-1 -: TAG_W];
      set_q <= req_addr[OFF_W +: SET_W];
      chk_q <= req_addr[CHK_LSB +: CHK_W];
      wr_q  <= req_write;
    end
    if (look_en) begin
      hit_q  <= lk_hit;
      way_q  <= lk_hit ? lk_way : vic_way;
      vtag_q <= vic_tag;
    end
  end

  assign req_ready  = (st_q == S_IDLE);
  assign resp_valid = (st_q == S_RESP);
  assign resp_hit   = hit_q;

  assign dram_valid = (st_q == S_WBRD) || (st_q == S_FWR) || (st_q == S_CHUNK);
  assign dram_write = (st_q == S_FWR) || ((st_q == S_CHUNK) && wr_q);
  assign dram_full  = (st_q != S_CHUNK);
  assign dram_addr  = {set_q, way_q, (st_q == S_CHUNK) ? chk_q : {CHK_W{1'b0}},
                       {CHK_LSB{1'b0}}};

  assign mem_valid = (st_q == S_WBWR) || (st_q == S_FRD);
  assign mem_write = (st_q == S_WBWR);
  assign mem_addr  = {(st_q == S_WBWR) ? vtag_q : tag_q, set_q, {OFF_W{1'b0}}};

  // R7
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (dram_valid || mem_valid) |-> !req_ready);

  // R7
  one_device_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !(dram_valid && mem_valid));

  // R8
  dram_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (dram_valid && !dram_done) |=>
      (dram_valid && $stable(dram_addr) && $stable(dram_write) && $stable(dram_full)));

  // R8
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (mem_valid && !mem_done) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));

  // R8
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_s)
    resp_valid |=> !resp_valid);

endmodule

// File: tb/dram_cache_tagctl_test.sv
module dram_cache_tagctl_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic        req_ready;
  logic [31:0] req_addr;
  logic        resp_valid, resp_hit;
  logic        dram_valid, dram_write, dram_full, dram_done;
  logic [16:0] dram_addr;
  logic        mem_valid, mem_write, mem_done;
  logic [31:0] mem_addr;

  always #5 clk = ~clk;

  dram_cache_tagctl uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .resp_valid(resp_valid), .resp_hit(resp_hit),
    .dram_valid(dram_valid), .dram_write(dram_write), .dram_full(dram_full),
    .dram_addr(dram_addr), .dram_done(dram_done),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr), .mem_done(mem_done)
  );

  // kind: 0 DRAM command, 1 main-memory command, 2 response
  typedef struct {
    int          kind;
    bit          wr;
    bit          full;
    logic [31:0] addr;
    bit          hit;
    string       rq;
  } ev_t;

  ev_t exp_q[$];
  int  errs = 0;
  int  checks = 0;
  bit  done_flag = 0;

  function automatic logic [31:0] la(int tag, int set, int ch);
    return 32'((tag << 14) | (set << 10) | (ch << 7));
  endfunction

  function automatic logic [31:0] da(int set, int way, int ch);
    return 32'((set * 8 + way) * 1024 + ch * 128);
  endfunction

  task automatic push(int kind, bit wr, bit full, logic [31:0] a, bit hit, string rq);
    ev_t e;
    e.kind = kind; e.wr = wr; e.full = full; e.addr = a; e.hit = hit; e.rq = rq;
    exp_q.push_back(e);
  endtask

  task automatic check_ev(int kind, bit wr, bit full, logic [31:0] a, bit hit);
    ev_t e;
    bit  bad;
    checks++;
    if (exp_q.size() == 0) begin
      errs++;
      $display("FAIL unexpected event: actual kind=%0d wr=%0d full=%0d addr=%h hit=%0d expected none (R2)",
               kind, wr, full, a, hit);
    end else begin
      e = exp_q.pop_front();
      bad = (e.kind != kind);
      if (!bad && kind != 2) bad = (e.wr != wr) || (e.addr != a) || (kind == 0 && e.full != full);
      if (!bad && kind == 2) bad = (e.hit != hit);
      if (bad) begin
        errs++;
        $display("FAIL %s: actual kind=%0d wr=%0d full=%0d addr=%h hit=%0d expected kind=%0d wr=%0d full=%0d addr=%h hit=%0d",
                 e.rq, kind, wr, full, a, hit, e.kind, e.wr, e.full, e.addr, e.hit);
      end
    end
  endtask

  // device models and monitor
  int dcnt = 0, mcnt = 0;
  bit prev_resp = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (dram_done) begin
        dram_done = 1'b0; dcnt = 0;
      end else if (dram_valid) begin
        dcnt++;
        if (dcnt == 2) begin
          check_ev(0, dram_write, dram_full, {15'd0, dram_addr}, 1'b0);
          dram_done = 1'b1;
        end
      end
      if (mem_done) begin
        mem_done = 1'b0; mcnt = 0;
      end else if (mem_valid) begin
        mcnt++;
        if (mcnt == 2) begin
          check_ev(1, mem_write, 1'b1, mem_addr, 1'b0);
          checks++;
          if (req_ready) begin
            errs++;
            $display("FAIL R7: actual req_ready=%0d expected 0 during miss", req_ready);
          end
          mem_done = 1'b1;
        end
      end
      if (prev_resp) begin
        checks++;
        if (resp_valid) begin
          errs++;
          $display("FAIL R8: actual resp_valid=%0d expected 0 after pulse", resp_valid);
        end
      end
      if (resp_valid) check_ev(2, 1'b0, 1'b0, 32'd0, resp_hit);
      prev_resp = resp_valid;
    end
  end

  task automatic issue(bit wr, logic [31:0] a);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    checks++;
    if (req_ready) begin
      errs++;
      $display("FAIL R7: actual req_ready=%0d expected 0 after accept", req_ready);
    end
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic miss(bit wr, int tag, int set, int ch, int way, bit dirty, int vtag, string rq);
    if (dirty) begin
      push(0, 1'b0, 1'b1, da(set, way, 0), 1'b0, "R5");
      push(1, 1'b1, 1'b1, la(vtag, set, 0), 1'b0, "R5");
    end
    push(1, 1'b0, 1'b1, la(tag, set, 0), 1'b0, rq);
    push(0, 1'b1, 1'b1, da(set, way, 0), 1'b0, rq);
    push(0, wr, 1'b0, da(set, way, ch), 1'b0, rq);
    push(2, 1'b0, 1'b0, 32'd0, 1'b0, rq);
    issue(wr, la(tag, set, ch));
  endtask

  task automatic hit(bit wr, int tag, int set, int ch, int way, string rq);
    push(0, wr, 1'b0, da(set, way, ch), 1'b0, rq);
    push(2, 1'b0, 1'b0, 32'd0, 1'b1, rq);
    issue(wr, la(tag, set, ch));
  endtask

  task automatic chk_bit(logic act, logic expv, string rq, string what);
    checks++;
    if (act !== expv) begin
      errs++;
      $display("FAIL %s %s: actual %0b expected %0b", rq, what, act, expv);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      errs++; checks++;
      $display("FAIL R7 watchdog: actual hung expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    dram_done = 1'b0; mem_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9 reset state
    chk_bit(req_ready, 1'b1, "R9", "req_ready");
    chk_bit(resp_valid, 1'b0, "R9", "resp_valid");
    chk_bit(dram_valid, 1'b0, "R9", "dram_valid");
    chk_bit(mem_valid, 1'b0, "R9", "mem_valid");

    // set 0: fill, hits, tree victim
    miss(1'b0, 1, 0, 3, 0, 1'b0, 0, "R4");
    hit(1'b0, 1, 0, 5, 0, "R2");
    for (int k = 1; k < 8; k++) miss(1'b0, k + 1, 0, 0, k, 1'b0, 0, "R6");
    hit(1'b1, 1, 0, 2, 0, "R2");
    miss(1'b0, 9, 0, 1, 4, 1'b0, 0, "R6");
    hit(1'b0, 1, 0, 0, 0, "R2");

    // set 1: write miss allocates modified line
    miss(1'b1, 1, 1, 4, 0, 1'b0, 0, "R10");
    for (int k = 1; k < 8; k++) miss(1'b0, k + 1, 1, 0, k, 1'b0, 0, "R4");
    miss(1'b0, 9, 1, 6, 0, 1'b1, 1, "R10");
    miss(1'b0, 1, 1, 0, 4, 1'b0, 0, "R11");

    // set 2: write hit marks modified
    miss(1'b0, 1, 2, 0, 0, 1'b0, 0, "R4");
    hit(1'b1, 1, 2, 7, 0, "R3");
    for (int k = 1; k < 8; k++) miss(1'b0, k + 1, 2, 0, k, 1'b0, 0, "R4");
    miss(1'b0, 9, 2, 0, 0, 1'b1, 1, "R3");

    // R1: high tag, last set, last chunk, junk low bits
    push(1, 1'b0, 1'b1, la((1 << 17) | 5, 15, 0), 1'b0, "R1");
    push(0, 1'b1, 1'b1, da(15, 0, 0), 1'b0, "R1");
    push(0, 1'b0, 1'b0, da(15, 0, 7), 1'b0, "R1");
    push(2, 1'b0, 1'b0, 32'd0, 1'b0, "R1");
    issue(1'b0, la((1 << 17) | 5, 15, 7) | 32'h55);
    hit(1'b0, (1 << 17) | 5, 15, 6, 0, "R1");

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule